// File: doc/BRIEF.md
# Debounced Push-Button Press Counter with Seven-Segment Output

This block tallies presses of a mechanical push button and presents the tally as one decimal digit on a seven-segment display. The raw button level is first brought into the clock domain through a two-flop synchronizer. A slow sampling enable, produced by a terminal-count divider of the system clock (about 100 Hz at the default setting), then clocks the synchronized level into a short shift register that rejects contact bounce.

A press is recognised only once the button has read high on every stored sample. The tally advances on the rising edge of that filtered level, so holding the button down yields a single step. The tally runs from 0 up to 10 and then wraps to 0. Values 0 to 9 drive active-low digit patterns, and the value 10 shows a dash. An active-high synchronous reset clears the tally. The anode select enables only the rightmost digit.

Top module: `press_tally_display`

## Requirements
- R1: A sampling enable pulses for one clock cycle once every TICK_DIV clock cycles, first at cycle TICK_DIV-1 after reset is released.
- R2: The button (high = pressed) passes through a two-flop synchronizer. It counts as pressed only after FILT_LEN consecutive sampling pulses have seen it high. A burst that spans fewer samples causes no increment.
- R3: A press advances the tally by exactly one, however long the button is held. The advance happens only on a sampling pulse.
- R4: The tally changes only on a recognised press or on reset.
- R5: While reset (active high, synchronous) is asserted, the tally is 0, `seg_n` is 7'b0000001 and `anode_n` is 4'b1110.
- R6: `seg_n` is active low with bit 6 = segment a down to bit 0 = segment g. Digits 0..9 map to 0000001, 1001111, 0010010, 0000110, 1001100, 0100100, 0100000, 0001111, 0000000 and 0000100. `seg_n` is registered and follows the tally one cycle later.
- R7: The tally wraps from COUNT_MAX (10) to 0 on the next press. Any tally above 9 shows the dash pattern 1111110.
- R8: `anode_n` is always 4'b1110, so only digit 0 is enabled (active low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| button | input | 1 | Raw push-button level, high when pressed |
| seg_n | output | 7 | Active-low segment lines, bit 6 = a, bit 0 = g |
| anode_n | output | 4 | Active-low digit enables |

## Verification
The bound checker watches every cycle for several properties. The sampling pulse must keep its exact spacing, and a press may only appear together with a pulse. The tally must stay inside its range, stay unchanged without a press, and wrap to zero after the top value. The anode select must stay fixed. Some behaviours depend on sequences that only the bench's scenarios produce. These are the rejection of bursts shorter than the filter depth, the single step for a long hold, the full digit table read back through the segment lines, and the reset image.

// File: rtl/press_tally_pkg.sv
package press_tally_pkg;

  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;

  // Active-low segments, bit 6 = a ... bit 0 = g
  function automatic logic [SEG_W-1:0] digit_to_seg(input logic [DIGIT_W-1:0] d);
    logic [SEG_W-1:0] s;
    case (d)
      4'd0:    s = 7'b0000001;
      4'd1:    s = 7'b1001111;
      4'd2:    s = 7'b0010010;
      4'd3:    s = 7'b0000110;
      4'd4:    s = 7'b1001100;
      4'd5:    s = 7'b0100100;
      4'd6:    s = 7'b0100000;
      4'd7:    s = 7'b0001111;
      4'd8:    s = 7'b0000000;
      4'd9:    s = 7'b0000100;
      default: s = 7'b1111110;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sample_tick.sv
module sample_tick #(
  parameter int TICK_DIV = 250000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst)                  div_cnt <= '0;
    else if (div_cnt == LAST) div_cnt <= '0;
    else                      div_cnt <= div_cnt + 1'b1;
  end

  assign tick = (div_cnt == LAST);
endmodule

// File: rtl/bounce_filter.sv
module bounce_filter #(
  parameter int FILT_LEN  = 4,
  parameter int SYNC_LEN  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic button,
  output logic press
);
  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_LEN-1:0] inv_hist;
  logic                level_q;
  logic                level;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_LEN-2:0], button};
  end

  // Inverted samples shift in; all-zero history means steadily pressed
  always_ff @(posedge clk) begin
    if (rst) begin
      inv_hist <= '1;
      level_q  <= 1'b0;
    end else if (tick) begin
      inv_hist <= {~sync_q[SYNC_LEN-1], inv_hist[FILT_LEN-1:1]};
      level_q  <= level;
    end
  end

  assign level = (inv_hist == '0);
  assign press = tick && level && !level_q;
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int COUNT_MAX = 10,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(COUNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (step) value <= (value == TOP) ? '0 : value + 1'b1;
  end
endmodule

// File: rtl/press_tally_display.sv
module press_tally_display
  import press_tally_pkg::*;
#(
  parameter int TICK_DIV  = 250000,
  parameter int FILT_LEN  = 4,
  parameter int COUNT_MAX = 10,
  parameter int AN_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             button,
  output logic [SEG_W-1:0] seg_n,
  output logic [AN_W-1:0]  anode_n
);
  localparam logic [AN_W-1:0] AN_ON = ~AN_W'(1);

  logic               tick_w;
  logic               press_w;
  logic [DIGIT_W-1:0] count_w;

  sample_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick_w)
  );

  bounce_filter #(.FILT_LEN(FILT_LEN), .SYNC_LEN(2)) u_filt (
    .clk(clk), .rst(rst), .tick(tick_w), .button(button), .press(press_w)
  );

  wrap_counter #(.COUNT_MAX(COUNT_MAX), .CNT_W(DIGIT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(press_w), .value(count_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n   <= digit_to_seg('0);
      anode_n <= AN_ON;
    end else begin
      seg_n   <= digit_to_seg(count_w);
      anode_n <= AN_ON;
    end
  end
endmodule

// File: rtl/press_tally_checker.sv
module press_tally_checker #(
  parameter int TICK_DIV  = 250000,
  parameter int COUNT_MAX = 10,
  parameter int CNT_W     = 4,
  parameter int AN_W      = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             press,
  input logic [CNT_W-1:0] count,
  input logic [AN_W-1:0]  anode_n
);
  localparam int GW = (TICK_DIV > 1) ? $clog2(TICK_DIV) + 1 : 2;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst || tick) gap <= '0;
    else             gap <= gap + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap == GW'(TICK_DIV - 1))); // R1
  AST_TICK_NOT_LATE: assert property (@(posedge clk) disable iff (rst)
    gap <= GW'(TICK_DIV - 1)); // R1
  AST_PRESS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    press |-> tick); // R3
  AST_HOLD_WITHOUT_PRESS: assert property (@(posedge clk) disable iff (rst)
    !press |=> $stable(count)); // R4
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(COUNT_MAX)); // R7
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (press && count == CNT_W'(COUNT_MAX)) |=> (count == '0)); // R7
  AST_ANODE_FIXED: assert property (@(posedge clk) disable iff (rst)
    anode_n == ~AN_W'(1)); // R8
endmodule

bind press_tally_display press_tally_checker #(
  .TICK_DIV(TICK_DIV), .COUNT_MAX(COUNT_MAX),
  .CNT_W(press_tally_pkg::DIGIT_W), .AN_W(AN_W)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick_w), .press(press_w),
  .count(count_w), .anode_n(anode_n)
);

// File: tb/press_tally_display_test.sv
module press_tally_display_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int HOLD       = 10 * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       button = 1'b0;
  logic [6:0] seg_n;
  logic [3:0] anode_n;
  int checks = 0;
  int failures = 0;

  // Expected segments after press k (k = 1..12): 1..9, dash for 10, wrap to 0, then 1
  localparam logic [6:0] EXP_SEG [12] = '{
    7'b1001111, 7'b0010010, 7'b0000110, 7'b1001100, 7'b0100100, 7'b0100000,
    7'b0001111, 7'b0000000, 7'b0000100, 7'b1111110, 7'b0000001, 7'b1001111
  };

  press_tally_display #(.TICK_DIV(DIV), .FILT_LEN(4), .COUNT_MAX(10), .AN_W(4)) uut (
    .clk(clk), .rst(rst), .button(button), .seg_n(seg_n), .anode_n(anode_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_seg(input string req, input logic [6:0] exp);
    checks++;
    if (seg_n !== exp) begin
      failures++;
      $display("FAIL %s seg_n actual=%b expected=%b", req, seg_n, exp);
    end
  endtask

  task automatic check_an(input string req);
    checks++;
    if (anode_n !== 4'b1110) begin
      failures++;
      $display("FAIL %s anode_n actual=%b expected=1110", req, anode_n);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clean_press();
    button = 1'b1;
    wait_cycles(HOLD);
    button = 1'b0;
    wait_cycles(HOLD);
  endtask

  initial begin
    wait_cycles(5);
    check_seg("R5", 7'b0000001);
    check_an("R5");
    rst = 1'b0;
    wait_cycles(2);

    // R6 R7 R3: walk through the digit table and the wrap
    for (int k = 0; k < 12; k++) begin
      clean_press();
      check_seg(k < 9 ? "R6" : "R7", EXP_SEG[k]);
    end
    check_an("R8");

    // R2: bursts of three samples high, one low, never reach four in a row
    for (int b = 0; b < 6; b++) begin
      button = 1'b1;
      wait_cycles(3 * DIV);
      button = 1'b0;
      wait_cycles(DIV);
    end
    wait_cycles(HOLD);
    check_seg("R2", 7'b1001111);

    // R3 R4: a long hold gives one step only
    button = 1'b1;
    wait_cycles(40 * DIV);
    check_seg("R3", 7'b0010010);
    button = 1'b0;
    wait_cycles(HOLD);
    check_seg("R4", 7'b0010010);

    // R5: reset clears the tally
    rst = 1'b1;
    wait_cycles(3);
    check_seg("R5", 7'b0000001);
    check_an("R5");
    rst = 1'b0;
    wait_cycles(2);
    clean_press();
    check_seg("R5", 7'b1001111);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule